// File: doc/BRIEF.md
# Port-Driven SPI Byte Engine

This block is an SPI master that a small coprocessor drives through a byte-wide register port. It moves exactly one byte per exchange and serves three serial targets that share one clock line and one data-out line: a memory card, the control interface of an audio decoder, and the data interface of the same decoder. Writing a channel's send register starts a full-duplex exchange of the written byte. The byte shifted in is kept per channel, so software can read it back afterwards.

For block reads from the card, a dedicated read register returns the last received card byte and, in the same access, starts a new exchange that sends all ones. A read loop can therefore stream a block without any write accesses. A control register drives the two chip selects and four auxiliary control lines, and reads back their state. A status register gathers four target-side flags.

Register map on `addr`: 0 = card send (write) / card receive (read); 1 = card read-and-restart (read); 2 = decoder data send (write); 3 = decoder control send (write) / decoder control receive (read); 4 = serial control (read/write); 5 = serial status (read).

Top module: `spiByteEngine`

## Requirements
- R1: After reset, `sck` is low, `busy` is low, `sdCsN` and `ctlCsN` are high, `auxCtl` is 0, and reading address 4 returns 0x03.
- R2: A write to address 0 while idle sets `busy` on the next cycle and shifts the written byte out on `mosi`, most significant bit first, in SPI mode 0: `mosi` is valid before each rising `sck` edge and does not change while `sck` is high.
- R3: Reading address 0 returns the byte that the most recent card exchange sampled from `sdMiso` on the rising `sck` edges, first bit in the most significant position.
- R4: A read of address 1 while idle returns the stored card byte and starts a new card exchange that sends 0xFF. `busy` is high after that access.
- R5: A write to address 3 exchanges a byte with `ctlMiso` as input. Reading address 3 returns the received byte, and the stored card byte is unchanged.
- R6: A write to address 2 sends a byte on the decoder data channel. `dataSel` is high only during that exchange, and neither stored receive byte changes.
- R7: A write to address 4 stores bits 5:0. Bit 0 drives `sdCsN`, bit 1 drives `ctlCsN`, bits 5:2 drive `auxCtl[3:0]` from the next cycle, and a read of address 4 returns the stored bits with bits 7:6 zero.
- R8: Reading address 5 returns `dataReq` in bit 0, `cardDet` in bit 1, `wrProt` in bit 2, `ctlReady` in bit 3 and zeros in bits 7:4.
- R9: Any start request (a send write, or a read of address 1) made while `busy` is high is ignored. The running exchange keeps its byte and length, and no extra exchange follows.
- R10: `sck` stays low whenever `busy` is low, and each exchange keeps `busy` high for exactly 16·HALF_DIV clock cycles (eight `sck` periods).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed for read side effects) |
| addr | input | 3 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| sdMiso | input | 1 | Serial input from the card |
| ctlMiso | input | 1 | Serial input from the decoder control interface |
| dataReq | input | 1 | Decoder data request flag |
| cardDet | input | 1 | Card present flag |
| wrProt | input | 1 | Card write-protect flag |
| ctlReady | input | 1 | Decoder control interface ready flag |
| sck | output | 1 | Shared serial clock, idle low |
| mosi | output | 1 | Shared serial data out |
| sdCsN | output | 1 | Card chip select, active low |
| ctlCsN | output | 1 | Decoder control chip select, active low |
| auxCtl | output | 4 | Auxiliary control lines |
| dataSel | output | 1 | High while a decoder data exchange runs |
| busy | output | 1 | Exchange in progress |

## Verification
Card exchanges run with transmit bytes 0x3C and 0x80 against slave bytes 0xA5 and 0x01. These patterns separate the MSB-first order from LSB-first and catch a stuck or shifted bit on either direction. A read-and-restart access then checks that the old byte comes back while 0xFF goes out. A send write and a restart read are issued while an exchange is running, to show that neither adds an exchange or corrupts it. Control and data channel exchanges follow, each with a different slave pattern, to show that every channel stores its result only in its own register.

// File: rtl/spiEnginePkg.sv
package spiEnginePkg;
  localparam logic [2:0] REG_SD_XFER   = 3'd0;
  localparam logic [2:0] REG_SD_RESTART = 3'd1;
  localparam logic [2:0] REG_DATA_SEND = 3'd2;
  localparam logic [2:0] REG_CTL_XFER  = 3'd3;
  localparam logic [2:0] REG_SCTL      = 3'd4;
  localparam logic [2:0] REG_SSTAT     = 3'd5;

  typedef enum logic [1:0] {CH_SD, CH_DATA, CH_CTL} chanE;

  typedef struct packed {
    logic       start;
    logic [7:0] txByte;
  } xferReqT;
endpackage

// File: rtl/spiShifter.sv
module spiShifter
  import spiEnginePkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferReqT           req,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(BYTE_W);

  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      bitCnt   <= '0;
      shiftReg <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req.start) begin
          busy     <= 1'b1;
          shiftReg <= req.txByte;
          mosi     <= req.txByte[BYTE_W-1];
          divCnt   <= '0;
          bitCnt   <= '0;
          sck      <= 1'b0;
        end
      end else if (divCnt == DIV_W'(HALF_DIV - 1)) begin
        divCnt <= '0;
        if (!sck) begin
          sck      <= 1'b1;
          shiftReg <= {shiftReg[BYTE_W-2:0], miso};
        end else begin
          sck    <= 1'b0;
          mosi   <= shiftReg[BYTE_W-1];
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == BIT_W'(BYTE_W - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign rxByte = shiftReg;
endmodule

// File: rtl/spiPortCtrl.sv
module spiPortCtrl
  import spiEnginePkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CTL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              sdMiso,
  input  logic              ctlMiso,
  input  logic              dataReq,
  input  logic              cardDet,
  input  logic              wrProt,
  input  logic              ctlReady,
  output xferReqT           req,
  output logic              miso,
  output logic              sdCsN,
  output logic              ctlCsN,
  output logic [CTL_W-3:0]  auxCtl,
  output logic              dataSel
);
  localparam logic [CTL_W-1:0] SCTL_RESET = CTL_W'(3);

  chanE              activeChan, reqChan;
  logic [BYTE_W-1:0] sdRx, ctlRx;
  logic [CTL_W-1:0]  sctlReg;

  always_comb begin
    req.start  = 1'b0;
    req.txByte = wrData;
    reqChan    = CH_SD;
    if (wrEn) begin
      case (addr)
        REG_SD_XFER:   req.start = 1'b1;
        REG_DATA_SEND: begin req.start = 1'b1; reqChan = CH_DATA; end
        REG_CTL_XFER:  begin req.start = 1'b1; reqChan = CH_CTL; end
        default: ;
      endcase
    end else if (rdEn && addr == REG_SD_RESTART) begin
      req.start  = 1'b1;
      req.txByte = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeChan <= CH_SD;
      sdRx       <= '0;
      ctlRx      <= '0;
      sctlReg    <= SCTL_RESET;
    end else begin
      if (req.start && !busy) activeChan <= reqChan;
      if (done) begin
        if (activeChan == CH_SD)  sdRx  <= rxByte;
        if (activeChan == CH_CTL) ctlRx <= rxByte;
      end
      if (wrEn && addr == REG_SCTL) sctlReg <= wrData[CTL_W-1:0];
    end
  end

  always_comb begin
    case (addr)
      REG_SD_XFER, REG_SD_RESTART: rdData = sdRx;
      REG_CTL_XFER: rdData = ctlRx;
      REG_SCTL:     rdData = BYTE_W'(sctlReg);
      REG_SSTAT:    rdData = BYTE_W'({ctlReady, wrProt, cardDet, dataReq});
      default:      rdData = '0;
    endcase
  end

  assign miso    = (activeChan == CH_SD) ? sdMiso :
                   (activeChan == CH_CTL) ? ctlMiso : 1'b0;
  assign dataSel = busy && (activeChan == CH_DATA);
  assign sdCsN   = sctlReg[0];
  assign ctlCsN  = sctlReg[1];
  assign auxCtl  = sctlReg[CTL_W-1:2];
endmodule

// File: rtl/spiByteEngine.sv
module spiByteEngine
  import spiEnginePkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       sdMiso,
  input  logic       ctlMiso,
  input  logic       dataReq,
  input  logic       cardDet,
  input  logic       wrProt,
  input  logic       ctlReady,
  output logic       sck,
  output logic       mosi,
  output logic       sdCsN,
  output logic       ctlCsN,
  output logic [3:0] auxCtl,
  output logic       dataSel,
  output logic       busy
);
  xferReqT    req;
  logic       miso, done;
  logic [7:0] rxByte;

  spiPortCtrl #(.BYTE_W(8), .CTL_W(6)) uCtrl (
    .clk, .rstN, .wrEn, .rdEn, .addr, .wrData, .rdData,
    .busy, .done, .rxByte, .sdMiso, .ctlMiso,
    .dataReq, .cardDet, .wrProt, .ctlReady,
    .req, .miso, .sdCsN, .ctlCsN, .auxCtl, .dataSel
  );

  spiShifter #(.BYTE_W(8), .HALF_DIV(HALF_DIV)) uShift (
    .clk, .rstN, .req, .miso, .sck, .mosi, .busy, .done, .rxByte
  );
endmodule

// File: rtl/spiByteEngineChk.sv
module spiByteEngineChk
  import spiEnginePkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [2:0] addr,
  input logic [7:0] wrData,
  input logic       busy,
  input logic       sck,
  input logic       mosi,
  input logic       sdCsN,
  input logic       ctlCsN,
  input logic       dataSel
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck); // R10

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi)); // R2

  AST_SEND_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_SD_XFER && !busy) |=> busy); // R2

  AST_RESTART_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == REG_SD_RESTART && !busy) |=> busy); // R4

  AST_CS_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_SCTL) |=> (sdCsN == $past(wrData[0]) && ctlCsN == $past(wrData[1]))); // R7

  AST_DATASEL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    dataSel |-> busy); // R6

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (wrEn || rdEn)) |=> $stable(dataSel) || !busy); // R9
endmodule

bind spiByteEngine spiByteEngineChk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .busy(busy), .sck(sck), .mosi(mosi),
  .sdCsN(sdCsN), .ctlCsN(ctlCsN), .dataSel(dataSel)
);

// File: tb/spiByteEngine_test.sv
module spiByteEngine_test;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic dataReq = 0, cardDet = 0, wrProt = 0, ctlReady = 0;
  logic sck, mosi, sdCsN, ctlCsN, dataSel, busy;
  logic [3:0] auxCtl;
  logic [7:0] sdSlave = '0, ctlSlave = '0;

  int compared = 0, mismatched = 0;
  int xferSeen = 0;
  logic [7:0] expTx[$];

  always #4 clk = ~clk;

  spiByteEngine #(.HALF_DIV(HALF_DIV)) uut (
    .clk, .rstN, .wrEn, .rdEn, .addr, .wrData, .rdData,
    .sdMiso(sdSlave[7]), .ctlMiso(ctlSlave[7]),
    .dataReq, .cardDet, .wrProt, .ctlReady,
    .sck, .mosi, .sdCsN, .ctlCsN, .auxCtl, .dataSel, .busy
  );

  always @(negedge sck) begin
    sdSlave  <= {sdSlave[6:0], 1'b0};
    ctlSlave <= {ctlSlave[6:0], 1'b0};
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: collect MOSI on rising SCK, compare each byte to the queue
  logic [7:0] monByte = '0;
  int monBits = 0;
  always @(posedge sck) begin
    monByte = {monByte[6:0], mosi};
    monBits++;
    if (monBits == 8) begin
      monBits = 0;
      xferSeen++;
      if (expTx.size() == 0) check("R9 unexpected exchange", {24'd0, monByte}, 32'hDEAD);
      else check("R2 mosi byte", {24'd0, monByte}, {24'd0, expTx.pop_front()});
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic sendByte(input logic [2:0] a, input logic [7:0] d);
    expTx.push_back(d);
    busWrite(a, d);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sck", sck, 0);
    check("R1 busy", busy, 0);
    check("R1 sdCsN", sdCsN, 1);
    check("R1 ctlCsN", ctlCsN, 1);
    check("R1 auxCtl", auxCtl, 0);
    busRead(3'd4, r); check("R1 sctl read", r, 8'h03);

    // R7 control register
    busWrite(3'd4, 8'hEA);
    check("R7 sdCsN", sdCsN, 0);
    check("R7 ctlCsN", ctlCsN, 1);
    check("R7 auxCtl", auxCtl, 4'b1010);
    busRead(3'd4, r); check("R7 sctl read", r, 8'h2A);

    // R8 status bit positions
    dataReq = 1; busRead(3'd5, r); check("R8 dataReq bit0", r, 8'h01);
    dataReq = 0; cardDet = 1; busRead(3'd5, r); check("R8 cardDet bit1", r, 8'h02);
    cardDet = 0; wrProt = 1; busRead(3'd5, r); check("R8 wrProt bit2", r, 8'h04);
    wrProt = 0; ctlReady = 1; busRead(3'd5, r); check("R8 ctlReady bit3", r, 8'h08);
    dataReq = 1; cardDet = 1; wrProt = 1; busRead(3'd5, r); check("R8 all", r, 8'h0F);

    // R2 R3 R10 card exchange
    sdSlave = 8'hA5;
    sendByte(3'd0, 8'h3C);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R10 busy length", n, 16 * HALF_DIV);
    check("R10 sck idle", sck, 0);
    repeat (2) @(negedge clk);
    busRead(3'd0, r); check("R3 card rx", r, 8'hA5);

    sdSlave = 8'h01;
    sendByte(3'd0, 8'h80);
    waitIdle();
    busRead(3'd0, r); check("R3 card rx lsb", r, 8'h01);

    // R4 read-and-restart
    sdSlave = 8'h5A;
    expTx.push_back(8'hFF);
    busRead(3'd1, r); check("R4 previous byte", r, 8'h01);
    check("R4 busy after", busy, 1);
    waitIdle();
    busRead(3'd0, r); check("R4 new byte", r, 8'h5A);

    // R9 starts while busy are ignored
    sdSlave = 8'hC3;
    n = xferSeen;
    sendByte(3'd0, 8'h11);
    busWrite(3'd0, 8'h22);
    busRead(3'd1, r); check("R9 restart read while busy", r, 8'h5A);
    waitIdle();
    repeat (4 * HALF_DIV) @(negedge clk);
    check("R9 busy stays low", busy, 0);
    check("R9 one exchange", xferSeen - n, 1);
    busRead(3'd0, r); check("R9 card rx", r, 8'hC3);

    // R5 decoder control channel
    ctlSlave = 8'h96; sdSlave = 8'h00;
    sendByte(3'd3, 8'h69);
    waitIdle();
    busRead(3'd3, r); check("R5 ctl rx", r, 8'h96);
    busRead(3'd0, r); check("R5 card rx kept", r, 8'hC3);

    // R6 decoder data channel
    sdSlave = 8'h0F; ctlSlave = 8'hF0;
    check("R6 dataSel idle", dataSel, 0);
    sendByte(3'd2, 8'h77);
    @(negedge clk);
    check("R6 dataSel active", dataSel, 1);
    waitIdle();
    check("R6 dataSel after", dataSel, 0);
    busRead(3'd0, r); check("R6 card rx kept", r, 8'hC3);
    busRead(3'd3, r); check("R6 ctl rx kept", r, 8'h96);

    check("R9 queue drained", expTx.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule